// File: doc/BRIEF.md
# SMBus block-mode configuration slave

This block is the serial control port of a clock generator. A host reaches a small bank of eight-bit control registers over a two-wire, SMBus-style block protocol. SCL and SDA come in asynchronously. A chain of flops brings them into the system clock, which must run at least ten times the bus bit rate. START, STOP and the SCL edges are found on the synchronized samples. The slave answers one fixed 7-bit device address and drives SDA only as an open-drain pull-down enable.

There is no register pointer. A write carries two leading bytes, a command and a count, which are acknowledged and thrown away. The bytes after them fill the bank from register 0 upward. A read first returns a fixed byte count and then the bank, again from register 0 upward. Register 0 is decoded into the generator's controls: the source of the 4-bit frequency selection (the register's own field or the external jumper pins), a spread-spectrum enable and a tristate request for all outputs. These controls are registered once before they leave the block.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte of 0xD2 (write) or 0xD3 (read), which is device address 0x69 with the direction in bit 0. Any other address gets no acknowledge, and the slave keeps SDA released for every later bit until the next START.
- R2: Every byte moves on the bus MSB first, bit 7 down to bit 0. Received bits are sampled on the SCL rising edge, and transmitted bits change after an SCL falling edge.
- R3: In a write, the slave acknowledges every byte. The first two bytes after the address are discarded. The next bytes go to registers 0, 1, 2 and so on, and bytes beyond the last of the NUM_REGS registers are discarded.
- R4: In a read, the first byte returned is the byte count 0x09. Registers 0, 1, 2 and so on follow it, and positions beyond the last register return 0x00.
- R5: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START.
- R6: A STOP in the middle of a byte ends the transfer, and the partly received byte is not stored. A START in the middle of a byte begins a new address phase at once.
- R7: When register 0 bit 3 is 1, the frequency-select output equals register 0 bits 7:4. When bit 3 is 0, it equals the 4-bit jumper input.
- R8: Register 0 bit 1 drives the spread-spectrum enable, and register 0 bit 0 drives the output-tristate request.
- R9: After reset, every register is 0x00, SDA is released, spread and tristate are low, and the frequency-select output follows the jumper input.
- R10: SDA is never driven while the bus is idle after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| fs_jumper_i | input | 4 | Frequency selection from the external jumpers |
| fs_sel_o | output | 4 | Frequency selection in effect |
| spread_en_o | output | 1 | Spread-spectrum enable |
| out_tristate_o | output | 1 | Tristate request for all clock outputs |

## Verification
The hardest states to reach from the ports are the aborts in the middle of a byte and the silence after an unmatched address or a read NACK. Each needs the bus frozen at one particular bit. The bench drives the bus with bit-level tasks. It can stop after any number of bits of a byte and issue a STOP or a repeated START. After a NACK or a wrong address it keeps clocking read slots to show that SDA stays high. A behavioural register model sees every write, and the bench compares the decoded control outputs and the released SDA against it on every idle clock.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    localparam int BYTE_W     = 8;
    localparam int FS_W       = 4;
    localparam int FS_LSB     = 4;
    localparam int SRC_BIT    = 3;
    localparam int SPREAD_BIT = 1;
    localparam int TRI_BIT    = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_TX,
        ST_TX,
        ST_ACK_RX,
        ST_IGNORE
    } smb_state_e;

    typedef struct packed {
        smb_state_e        state;
        logic [3:0]        bitcnt;
        logic [BYTE_W-1:0] shift;
        logic [7:0]        byte_idx;
        logic              rw;
        logic              oe;
        logic              nack;
    } smb_ctl_t;

    typedef struct packed {
        logic [FS_W-1:0] fs_sel;
        logic            spread;
        logic            tristate;
    } smb_ctrl_out_t;

endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] line_in;
    logic [NLINES-1:0] line_s;
    logic [NLINES-1:0] line_prev;

    assign line_in = {sda_i, scl_i};

    for (genvar gl = 0; gl < NLINES; gl++) begin : g_line
        logic [SYNC_STAGES-1:0] pipe_d, pipe_q;
        logic                   prev_q;

        always_comb begin
            pipe_d = {pipe_q[SYNC_STAGES-2:0], line_in[gl]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= '1;
                prev_q <= 1'b1;
            end else begin
                pipe_q <= pipe_d;
                prev_q <= pipe_q[SYNC_STAGES-1];
            end
        end

        assign line_s[gl]    = pipe_q[SYNC_STAGES-1];
        assign line_prev[gl] = prev_q;
    end

    assign scl_s     = line_s[0];
    assign sda_s     = line_s[1];
    assign scl_rise  = line_s[0] & ~line_prev[0];
    assign scl_fall  = ~line_s[0] & line_prev[0];
    assign start_det = line_s[0] & line_prev[0] & line_prev[1] & ~line_s[1];
    assign stop_det  = line_s[0] & line_prev[0] & ~line_prev[1] & line_s[1];

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
    import smb_cfg_pkg::*;
#(
    parameter int NUM_REGS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [7:0]        rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] reg0_o,
    input  logic [FS_W-1:0]   fs_jumper_i,
    output logic [FS_W-1:0]   fs_sel_o,
    output logic              spread_en_o,
    output logic              out_tristate_o
);

    logic [BYTE_W-1:0] bank_d [NUM_REGS];
    logic [BYTE_W-1:0] bank_q [NUM_REGS];
    smb_ctrl_out_t     out_d, out_q;

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            bank_d[i] = (wr_en && wr_idx == 8'(i)) ? wr_data : bank_q[i];
        end
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == 8'(i)) begin
                rd_data = bank_q[i];
            end
        end
        out_d.fs_sel   = bank_q[0][SRC_BIT] ? bank_q[0][FS_LSB +: FS_W] : fs_jumper_i;
        out_d.spread   = bank_q[0][SPREAD_BIT];
        out_d.tristate = bank_q[0][TRI_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                bank_q[i] <= '0;
            end
            out_q <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                bank_q[i] <= bank_d[i];
            end
            out_q <= out_d;
        end
    end

    assign reg0_o         = bank_q[0];
    assign fs_sel_o       = out_q.fs_sel;
    assign spread_en_o    = out_q.spread;
    assign out_tristate_o = out_q.tristate;

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h69,
    parameter int                NUM_REGS    = 6,
    parameter logic [BYTE_W-1:0] BYTE_COUNT  = 8'h09,
    parameter int                SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe_o,
    input  logic [FS_W-1:0] fs_jumper_i,
    output logic [FS_W-1:0] fs_sel_o,
    output logic            spread_en_o,
    output logic            out_tristate_o
);

    localparam logic [7:0] WR_SKIP = 8'd3;
    localparam logic [7:0] RD_SKIP = 8'd2;
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic reg_we;
    logic [7:0] nidx, rd_idx, wr_idx;
    logic [BYTE_W-1:0] rd_data, tx_byte, reg0;
    smb_ctl_t ctl_d, ctl_q;

    smb_bus_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_cfg_regs #(
        .NUM_REGS(NUM_REGS)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (reg_we),
        .wr_idx         (wr_idx),
        .wr_data        (ctl_q.shift),
        .rd_idx         (rd_idx),
        .rd_data        (rd_data),
        .reg0_o         (reg0),
        .fs_jumper_i    (fs_jumper_i),
        .fs_sel_o       (fs_sel_o),
        .spread_en_o    (spread_en_o),
        .out_tristate_o (out_tristate_o)
    );

    // position of the next byte: 1 is the count byte on reads, 2.. the bank
    assign nidx    = (ctl_q.byte_idx == 8'hFF) ? 8'hFF : ctl_q.byte_idx + 8'd1;
    assign rd_idx  = nidx - RD_SKIP;
    assign wr_idx  = ctl_q.byte_idx - WR_SKIP;
    assign tx_byte = (nidx == 8'd1) ? BYTE_COUNT : rd_data;

    always_comb begin
        ctl_d  = ctl_q;
        reg_we = 1'b0;
        unique case (ctl_q.state)
            ST_RX: begin
                if (scl_rise && ctl_q.bitcnt < LAST_BIT) begin
                    ctl_d.shift  = {ctl_q.shift[BYTE_W-2:0], sda_s};
                    ctl_d.bitcnt = ctl_q.bitcnt + 4'd1;
                end else if (scl_fall && ctl_q.bitcnt == LAST_BIT) begin
                    if (ctl_q.byte_idx == 8'd0) begin
                        if (ctl_q.shift[BYTE_W-1:1] == DEV_ADDR) begin
                            ctl_d.rw    = ctl_q.shift[0];
                            ctl_d.oe    = 1'b1;
                            ctl_d.state = ST_ACK_TX;
                        end else begin
                            ctl_d.state = ST_IGNORE;
                        end
                    end else begin
                        reg_we      = !ctl_q.rw && (ctl_q.byte_idx >= WR_SKIP);
                        ctl_d.oe    = 1'b1;
                        ctl_d.state = ST_ACK_TX;
                    end
                end
            end
            ST_ACK_TX: begin
                if (scl_fall) begin
                    ctl_d.byte_idx = nidx;
                    if (ctl_q.rw) begin
                        ctl_d.shift  = {tx_byte[BYTE_W-2:0], 1'b0};
                        ctl_d.oe     = ~tx_byte[BYTE_W-1];
                        ctl_d.bitcnt = 4'd1;
                        ctl_d.state  = ST_TX;
                    end else begin
                        ctl_d.oe     = 1'b0;
                        ctl_d.bitcnt = 4'd0;
                        ctl_d.state  = ST_RX;
                    end
                end
            end
            ST_TX: begin
                if (scl_fall) begin
                    if (ctl_q.bitcnt == LAST_BIT) begin
                        ctl_d.oe    = 1'b0;
                        ctl_d.state = ST_ACK_RX;
                    end else begin
                        ctl_d.oe     = ~ctl_q.shift[BYTE_W-1];
                        ctl_d.shift  = {ctl_q.shift[BYTE_W-2:0], 1'b0};
                        ctl_d.bitcnt = ctl_q.bitcnt + 4'd1;
                    end
                end
            end
            ST_ACK_RX: begin
                if (scl_rise) begin
                    ctl_d.nack = sda_s;
                end else if (scl_fall) begin
                    if (ctl_q.nack) begin
                        ctl_d.state = ST_IGNORE;
                    end else begin
                        ctl_d.byte_idx = nidx;
                        ctl_d.shift    = {tx_byte[BYTE_W-2:0], 1'b0};
                        ctl_d.oe       = ~tx_byte[BYTE_W-1];
                        ctl_d.bitcnt   = 4'd1;
                        ctl_d.state    = ST_TX;
                    end
                end
            end
            default: begin
            end
        endcase

        if (start_det) begin
            ctl_d       = '0;
            ctl_d.state = ST_RX;
            reg_we      = 1'b0;
        end else if (stop_det) begin
            ctl_d.state = ST_IDLE;
            ctl_d.oe    = 1'b0;
            reg_we      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe_o = ctl_q.oe;

endmodule

// File: rtl/smb_cfg_checker.sv
module smb_cfg_checker
    import smb_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              start_det,
    input logic              stop_det,
    input smb_state_e        state,
    input logic [3:0]        bitcnt,
    input logic [7:0]        byte_idx,
    input logic              rw,
    input logic              reg_we,
    input logic [BYTE_W-1:0] reg0,
    input logic [FS_W-1:0]   fs_jumper,
    input logic [FS_W-1:0]   fs_sel,
    input logic              spread,
    input logic              tristate
);

    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    p_start_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RX && bitcnt == 4'd0 && byte_idx == 8'd0));

    p_ignore_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IGNORE |-> !sda_oe);

    p_master_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ACK_RX |-> !sda_oe);

    p_write_only_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (!rw && byte_idx >= 8'd3));

    p_fs_from_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg0[SRC_BIT] |=> fs_sel == $past(reg0[FS_LSB +: FS_W]));

    p_fs_from_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg0[SRC_BIT] |=> fs_sel == $past(fs_jumper));

    p_spread_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> spread == $past(reg0[SPREAD_BIT]));

    p_tristate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tristate == $past(reg0[TRI_BIT]));

endmodule

bind smb_cfg_slave smb_cfg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe_o),
    .start_det (start_det),
    .stop_det  (stop_det),
    .state     (ctl_q.state),
    .bitcnt    (ctl_q.bitcnt),
    .byte_idx  (ctl_q.byte_idx),
    .rw        (ctl_q.rw),
    .reg_we    (reg_we),
    .reg0      (reg0),
    .fs_jumper (fs_jumper_i),
    .fs_sel    (fs_sel_o),
    .spread    (spread_en_o),
    .tristate  (out_tristate_o)
);

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 5;
    localparam int NREG       = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       bus_sda;
    logic [3:0] jumper = 4'hA;
    logic [3:0] fs_sel;
    logic       spread, tristate;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  model_valid = 1'b0;
    logic [7:0] model_reg [NREG];

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign bus_sda = sda_m & ~sda_oe;

    smb_cfg_slave u_smb_cfg_slave (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (scl_m),
        .sda_i          (bus_sda),
        .sda_oe_o       (sda_oe),
        .fs_jumper_i    (jumper),
        .fs_sel_o       (fs_sel),
        .spread_en_o    (spread),
        .out_tristate_o (out_tristate_unused_guard)
    );
    logic out_tristate_unused_guard;
    assign tristate = out_tristate_unused_guard;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_fs();
        return model_reg[0][3] ? model_reg[0][7:4] : jumper;
    endfunction

    // every idle clock: decoded controls match the model, SDA released (R7 R8 R10)
    always @(negedge clk) begin
        if (rst_n && model_valid) begin
            chk(fs_sel == exp_fs(), "R7", fs_sel, exp_fs());
            chk(spread == model_reg[0][1], "R8", spread, model_reg[0][1]);
            chk(tristate == model_reg[0][0], "R8", tristate, model_reg[0][0]);
            chk(sda_oe == 1'b0, "R10", sda_oe, 0);
        end
    end

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        model_valid = 1'b0;
        sda_m = 1'b1; waitq(QTR);
        scl_m = 1'b1; waitq(QTR);
        sda_m = 1'b0; waitq(QTR);
        scl_m = 1'b0; waitq(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq(QTR);
        scl_m = 1'b1; waitq(QTR);
        sda_m = 1'b1; waitq(QTR);
        waitq(4);
        model_valid = 1'b1;
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    waitq(QTR);
        scl_m = 1'b1; waitq(2 * QTR);
        scl_m = 1'b0; waitq(QTR);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; waitq(QTR);
        scl_m = 1'b1; waitq(QTR);
        b = bus_sda;  waitq(QTR);
        scl_m = 1'b0; waitq(QTR);
    endtask

    task automatic wr_byte(input logic [7:0] v, output bit acked);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(x);
        acked = !x;
    endtask

    task automatic rd_byte(output logic [7:0] v, input bit give_ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(x);
            v[i] = x;
        end
        send_bit(!give_ack);
    endtask

    // write transaction: address, command, count, then data to regs 0.. (R3)
    task automatic write_regs(input logic [7:0] vals [], input string req);
        bit a;
        bus_start();
        wr_byte(8'hD2, a); chk(a, "R1", a, 1);
        wr_byte(8'h5C, a); chk(a, "R3", a, 1);
        wr_byte(8'h02, a); chk(a, "R3", a, 1);
        for (int i = 0; i < vals.size(); i++) begin
            wr_byte(vals[i], a);
            chk(a, req, a, 1);
            if (i < NREG) model_reg[i] = vals[i];
        end
        bus_stop();
    endtask

    // read transaction of n bank bytes, compared with the model (R4)
    task automatic read_check(input int n, input string req);
        bit a;
        logic [7:0] v;
        logic [7:0] e;
        bus_start();
        wr_byte(8'hD3, a); chk(a, "R1", a, 1);
        rd_byte(v, 1'b1);  chk(v == 8'h09, "R4", v, 8'h09);
        for (int i = 0; i < n; i++) begin
            e = (i < NREG) ? model_reg[i] : 8'h00;
            rd_byte(v, i != n - 1);
            chk(v == e, req, v, e);
        end
        bus_stop();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    initial begin
        bit a;
        logic x;
        logic [7:0] v;
        for (int i = 0; i < NREG; i++) model_reg[i] = 8'h00;
        waitq(4);
        rst_n = 1'b1;
        waitq(4);
        // R9 reset state
        chk(sda_oe == 1'b0, "R9", sda_oe, 0);
        chk(fs_sel == 4'hA, "R9", fs_sel, 4'hA);
        chk(spread == 1'b0 && tristate == 1'b0, "R9", {spread, tristate}, 0);
        model_valid = 1'b1;

        // R2 R7 R8: reg0 = 1111_1001 selects its own FS field and tristates
        write_regs('{8'hF9, 8'h5A}, "R3");
        chk(fs_sel == 4'hF, "R7", fs_sel, 4'hF);
        chk(tristate == 1'b1 && spread == 1'b0, "R8", {spread, tristate}, 1);
        read_check(3, "R4");

        // R7 R8: reg0 = 0011_0110 takes FS from the jumpers, spread on
        write_regs('{8'h36}, "R3");
        chk(fs_sel == 4'hA, "R7", fs_sel, 4'hA);
        chk(spread == 1'b1 && tristate == 1'b0, "R8", {spread, tristate}, 2);
        model_valid = 1'b0;
        jumper = 4'h5;
        waitq(3);
        chk(fs_sel == 4'h5, "R7", fs_sel, 4'h5);
        model_valid = 1'b1;

        // R1: wrong address, no ack, later bytes ignored too
        bus_start();
        wr_byte(8'hA4, a); chk(!a, "R1", a, 0);
        wr_byte(8'hD2, a); chk(!a, "R1", a, 0);
        wr_byte(8'hFF, a); chk(!a, "R1", a, 0);
        bus_stop();
        read_check(1, "R1");

        // R3 R4: more data bytes than registers; extras dropped, reads 0x00
        write_regs('{8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65, 8'h76, 8'h87}, "R3");
        read_check(NREG + 2, "R4");

        // R5: NACK on the count byte, then the slave stays silent
        bus_start();
        wr_byte(8'hD3, a); chk(a, "R1", a, 1);
        rd_byte(v, 1'b0);  chk(v == 8'h09, "R4", v, 8'h09);
        for (int i = 0; i < 9; i++) begin
            recv_bit(x);
            chk(x == 1'b1, "R5", x, 1);
        end
        bus_stop();

        // R6: STOP after four bits of a data byte, nothing stored
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);
        wr_byte(8'h01, a);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        read_check(2, "R6");

        // R6: repeated START three bits into a byte begins a new address
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);
        wr_byte(8'h01, a);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_start();
        wr_byte(8'hD3, a); chk(a, "R6", a, 1);
        rd_byte(v, 1'b1);  chk(v == 8'h09, "R6", v, 8'h09);
        rd_byte(v, 1'b0);  chk(v == model_reg[0], "R6", v, model_reg[0]);
        bus_stop();

        // R2: a byte and its bit reverse land differently
        write_regs('{8'h1E, 8'h78}, "R2");
        read_check(2, "R2");

        waitq(10);
        finish_run();
    end

endmodule